// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating dual-slope analogue-to-digital converter. On a start pulse it first holds the external integrator in reset for a short, fixed number of clocks. It then connects the unknown input to the integrator for a fixed number of clock ticks (run-up). After that it switches the integrator over to a negative reference of known magnitude and counts clock ticks from zero until the comparator reports that the integrator output has come back to zero (run-down). The run-down count is the conversion result, and it is proportional to the charge gathered during run-up.

The analogue integrator, reference and comparator sit outside the block. The block drives two switch-select lines: one connects the input and one connects the negative reference. With both lines low, the integrator input is open. The block also drives a reset line for the integrator. If the comparator has not tripped after the full result range of run-down ticks, the result saturates at all ones and an overrange flag is set. Each finished conversion is marked by a one-cycle done pulse. The result and flag hold their values until the next done pulse.

Top module: `dsc_ctrl`

## Requirements
- R1: Each conversion drives `sw_in_o` high for exactly INT_TICKS consecutive clock cycles (default 64), and `sw_ref_o` stays low during that time.
- R2: Before run-up, `int_clr_o` is high for exactly CLR_TICKS consecutive cycles (default 2) with both switch lines low. It falls in the same cycle that `sw_in_o` rises, and it first goes high on the first clock edge after the start pulse is sampled.
- R3: `sw_ref_o` goes high in the cycle after the last run-up cycle, and run-down counting restarts at zero in that first run-down cycle.
- R4: Run-down cycles are numbered from 0. The result is the number of the first run-down cycle in which `cmp_zero_i` is high, provided that number is below 2^CNT_W. Run-down ends in that cycle, and `done_o` is high in the following cycle with the new result.
- R5: With a constant input that adds v charge units per run-up tick and a reference that removes r units per run-down tick, the result equals ceil(INT_TICKS*v/r). The result is therefore proportional to the integrated charge.
- R6: If `cmp_zero_i` has stayed low through run-down cycles 0 to 2^CNT_W-1, run-down ends in cycle 2^CNT_W whatever the comparator shows. The result is then all ones and `ovr_o` is 1. A trip in cycle 2^CNT_W-1 gives all ones with `ovr_o` = 0.
- R7: A start pulse that arrives while a conversion is running is ignored. The running conversion keeps its timing and result, and no further conversion follows it.
- R8: `done_o` is high for exactly one cycle per conversion. `result_o` and `ovr_o` change only in a cycle in which `done_o` is high.
- R9: While reset is asserted and after it is released, all outputs are 0 until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begins a conversion when the block is idle |
| cmp_zero_i | input | 1 | Comparator: high when the integrator output is at or below zero |
| sw_in_o | output | 1 | Connects the input voltage to the integrator |
| sw_ref_o | output | 1 | Connects the negative reference to the integrator |
| int_clr_o | output | 1 | Holds the integrator in reset |
| done_o | output | 1 | One-cycle pulse marking a finished conversion |
| result_o | output | CNT_W | Run-down count of the last conversion |
| ovr_o | output | 1 | Last conversion ran past the result range |

## Verification
Two events can fall in the same run-down cycle: the comparator trip and the range limit. This happens when the integrated charge is exactly 2^CNT_W reference steps. The bench sets this up with an input level whose integrated charge reaches zero exactly in run-down cycle 256. It expects saturation with the overrange flag set, and it also checks the neighbouring level, which trips one cycle earlier, is a valid all-ones result and leaves the flag clear. A second overlap comes from start pulses injected during run-up. These are judged by the phase lengths and by the absence of any restart after done.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLEAR = 2'd1,
    PH_INTEG = 2'd2,
    PH_DEINT = 2'd3
  } phase_t;
endpackage

// File: rtl/dsc_tick_cnt.sv
module dsc_tick_cnt #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [TW-1:0] cnt_o
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq
  import dsc_pkg::*;
#(
  parameter int TW        = 9,
  parameter int CNT_W     = 8,
  parameter int CLR_TICKS = 2,
  parameter int INT_TICKS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_zero_i,
  input  logic [TW-1:0] cnt_i,
  output phase_t        phase_o,
  output logic          cnt_clr_o,
  output logic          cnt_en_o,
  output logic          cap_o,
  output logic          ovr_o
);
  localparam logic [TW-1:0] CLR_LAST = TW'(CLR_TICKS - 1);
  localparam logic [TW-1:0] INT_LAST = TW'(INT_TICKS - 1);
  localparam logic [TW-1:0] FULL     = TW'(1) << CNT_W;

  phase_t phase_q, phase_d;

  always_comb begin
    phase_d   = phase_q;
    cnt_clr_o = 1'b0;
    cnt_en_o  = 1'b0;
    cap_o     = 1'b0;
    ovr_o     = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d   = PH_CLEAR;
          cnt_clr_o = 1'b1;
        end
      end
      PH_CLEAR: begin
        if (cnt_i == CLR_LAST) begin
          phase_d   = PH_INTEG;
          cnt_clr_o = 1'b1;
        end else begin
          cnt_en_o = 1'b1;
        end
      end
      PH_INTEG: begin
        if (cnt_i == INT_LAST) begin
          phase_d   = PH_DEINT;
          cnt_clr_o = 1'b1;
        end else begin
          cnt_en_o = 1'b1;
        end
      end
      PH_DEINT: begin
        if (cnt_i == FULL) begin
          phase_d = PH_IDLE;
          cap_o   = 1'b1;
          ovr_o   = 1'b1;
        end else if (cmp_zero_i) begin
          phase_d = PH_IDLE;
          cap_o   = 1'b1;
        end else begin
          cnt_en_o = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  AST_CLR_LEADS_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == PH_INTEG) |-> $past(phase_q == PH_CLEAR)); // R2
  AST_INTEG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_INTEG && cnt_i != INT_LAST) |=> (phase_q == PH_INTEG)); // R1
  AST_DEINT_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == PH_DEINT) |-> (cnt_i == '0)); // R3
  AST_DEINT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DEINT) |-> (cnt_i <= FULL)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DEINT && start_i) |=> (phase_q != PH_CLEAR)); // R7
endmodule

// File: rtl/dsc_result.sv
module dsc_result #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             ovr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] result_o,
  output logic             ovr_o,
  output logic             done_o
);
  logic [CNT_W-1:0] res_q, res_d;
  logic             ovr_q, ovr_d;
  logic             done_q;

  always_comb begin
    res_d = res_q;
    ovr_d = ovr_q;
    if (cap_i) begin
      res_d = ovr_i ? '1 : cnt_i;
      ovr_d = ovr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      ovr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      ovr_q  <= ovr_d;
      done_q <= cap_i;
    end
  end

  assign result_o = res_q;
  assign ovr_o    = ovr_q;
  assign done_o   = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(res_q) && $stable(ovr_q))); // R8
  AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> (&res_q)); // R6
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int CLR_TICKS = 2,
  parameter int INT_TICKS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_zero_i,
  output logic             sw_in_o,
  output logic             sw_ref_o,
  output logic             int_clr_o,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o,
  output logic             ovr_o
);
  localparam int IW = $clog2(INT_TICKS + 1);
  localparam int TW = (IW > CNT_W + 1) ? IW : CNT_W + 1;

  logic          rst_meta, rst_sync;
  logic [TW-1:0] cnt;
  logic          cnt_clr, cnt_en, cap, ovr_hit;
  phase_t        phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dsc_tick_cnt #(.TW(TW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  dsc_seq #(
    .TW        (TW),
    .CNT_W     (CNT_W),
    .CLR_TICKS (CLR_TICKS),
    .INT_TICKS (INT_TICKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync),
    .start_i    (start_i),
    .cmp_zero_i (cmp_zero_i),
    .cnt_i      (cnt),
    .phase_o    (phase),
    .cnt_clr_o  (cnt_clr),
    .cnt_en_o   (cnt_en),
    .cap_o      (cap),
    .ovr_o      (ovr_hit)
  );

  dsc_result #(.CNT_W(CNT_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_sync),
    .cap_i    (cap),
    .ovr_i    (ovr_hit),
    .cnt_i    (cnt[CNT_W-1:0]),
    .result_o (result_o),
    .ovr_o    (ovr_o),
    .done_o   (done_o)
  );

  assign int_clr_o = (phase == PH_CLEAR);
  assign sw_in_o   = (phase == PH_INTEG);
  assign sw_ref_o  = (phase == PH_DEINT);

  AST_SWITCH_EXCL: assert property (@(posedge clk) disable iff (!rst_sync)
    !(sw_in_o && sw_ref_o) && !(int_clr_o && (sw_in_o || sw_ref_o))); // R2
  AST_DONE_ENDS_RUNDOWN: assert property (@(posedge clk) disable iff (!rst_sync)
    done_o |-> ($past(sw_ref_o) && !sw_ref_o)); // R4
endmodule

// File: tb/dsc_ctrl_bench.sv
module dsc_ctrl_bench;
  localparam int CNT_W = 8;
  localparam int CLR_TICKS = 2;
  localparam int INT_TICKS = 64;
  localparam int REF_STEP = 37;
  localparam int FULL = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic sw_in, sw_ref, int_clr, done, ovr;
  logic [CNT_W-1:0] result;

  int total = 0;
  int bad = 0;
  int charge = 0;
  int vin = 0;

  always #10 clk = ~clk;

  dsc_ctrl #(.CNT_W(CNT_W), .CLR_TICKS(CLR_TICKS), .INT_TICKS(INT_TICKS)) u_dsc_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_zero_i(cmp),
    .sw_in_o(sw_in), .sw_ref_o(sw_ref), .int_clr_o(int_clr),
    .done_o(done), .result_o(result), .ovr_o(ovr)
  );

  // analogue integrator model in charge units
  always @(posedge clk) begin
    if (int_clr)     charge <= 0;
    else if (sw_in)  charge <= charge + vin;
    else if (sw_ref) charge <= charge - REF_STEP;
  end
  assign cmp = (charge <= 0);

  function automatic int exp_k(int v);
    return (INT_TICKS * v + REF_STEP - 1) / REF_STEP;
  endfunction
  function automatic int exp_res(int v);
    return (exp_k(v) >= FULL) ? FULL - 1 : exp_k(v);
  endfunction
  function automatic int exp_ref(int v);
    return (exp_k(v) >= FULL) ? FULL + 1 : exp_k(v) + 1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_conv(int v, bit poke);
    int n = 0, in_cnt = 0, ref_cnt = 0, clr_cnt = 0, moved = 0;
    bit poked = 0, clr_ok = 1, in_run = 1;
    logic [CNT_W-1:0] prev_res = result;
    logic prev_ovr = ovr;
    vin = v;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(int_clr === 1'b1, "R2", "clear after start", int'(int_clr), 1);
    while (done !== 1'b1 && n < 2000) begin
      if (int_clr) begin clr_cnt++; if (sw_in || sw_ref) clr_ok = 0; end
      if (sw_in) begin
        if (in_cnt != 0 && !in_run) clr_ok = 0;
        in_cnt++;
        if (sw_ref) clr_ok = 0;
      end
      in_run = sw_in;
      if (sw_ref) ref_cnt++;
      if (result !== prev_res || ovr !== prev_ovr) moved++;
      if (poke && in_cnt == 10 && !poked) begin start = 1'b1; poked = 1; end
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n < 2000, "R4", "conversion finished", n, 0);
    chk(in_cnt == INT_TICKS, "R1", "run-up length", in_cnt, INT_TICKS);
    chk(clr_cnt == CLR_TICKS && clr_ok, "R2", "clear length/exclusive", clr_cnt, CLR_TICKS);
    chk(ref_cnt == exp_ref(v), "R3", "run-down cycles", ref_cnt, exp_ref(v));
    chk(int'(result) == exp_res(v), "R5", "result", int'(result), exp_res(v));
    chk(ovr === (exp_k(v) >= FULL), "R6", "overrange flag", int'(ovr), int'(exp_k(v) >= FULL));
    chk(moved == 0, "R8", "result held before done", moved, 0);
    prev_res = result;
    @(negedge clk);
    chk(done === 1'b0, "R8", "done single cycle", int'(done), 0);
    chk(result === prev_res, "R8", "result held after done", int'(result), int'(prev_res));
    if (poke) begin
      chk(poked, "R7", "start was injected", int'(poked), 1);
      chk(!int_clr && !sw_in && !sw_ref, "R7", "no restart after done",
          int'({int_clr, sw_in, sw_ref}), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4480));
    repeat (3) @(negedge clk);
    chk({sw_in, sw_ref, int_clr, done, ovr} === 5'b0 && result === '0, "R9",
        "outputs in reset", int'({sw_in, sw_ref, int_clr, done, ovr}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({sw_in, sw_ref, int_clr, done, ovr} === 5'b0 && result === '0, "R9",
        "outputs idle after reset", int'({sw_in, sw_ref, int_clr, done, ovr}), 0);
    do_conv(0, 0);    // R4: trip in run-down cycle 0
    do_conv(1, 0);    // R5: ceil(64/37)=2
    do_conv(147, 0);  // R6: trip in cycle 255, no overrange
    do_conv(148, 0);  // R6: trip and limit both in cycle 256
    do_conv(230, 0);  // R6: far past range
    do_conv(60, 1);   // R7: start injected in run-up
    do_conv(100, 0);
    for (int i = 0; i < 25; i++) begin
      do_conv(int'($urandom_range(0, 170)), ($urandom_range(0, 3) == 0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule